// File: doc/BRIEF.md
# Call/Return Stack Engine

This block keeps a byte-wide stack in data memory for an 8-bit processor whose program counter is 22 bits wide. The core hands it one operation at a time: push a byte, pop a byte, call (absolute or relative) or return. The block then moves the bytes through a single memory port, one byte per clock, and reports the outcome with a one-cycle `done` pulse. For calls and returns it also presents the new program counter on `pc_new`, qualified by `pc_load`.

The 16-bit stack pointer lives inside the block. Its two bytes appear to the core as two addresses in the I/O space, so software can read and write them like any other location. A push stores at the pointer and then moves the pointer down. A pop first moves the pointer up and then reads. A call stacks the three-byte return address with the top byte first. A return reads it back with the bottom byte first. Any byte whose address is not below the memory size aborts the operation with an error flag.

Top module: `stack_engine`

## Requirements
- R1: After a synchronous active-low reset, `sp_q` equals `SP_RESET` (default `MEM_BYTES-1` = 0x0FFF), and `busy`, `done` and `pc_load` are low.
- R2: A push (`op_kind` = 0) writes `push_byte` at address `sp_q` in one memory cycle. The pointer then becomes `sp_q-1`.
- R3: A pop (`op_kind` = 1) increments the pointer and reads the byte at the new pointer in one memory cycle. That byte is shown on `pop_byte` while `done` is high.
- R4: A call (`op_kind` = 2) writes `ret_pc` bits 23:16 (zero-extended), then bits 15:8, then bits 7:0, at `sp_q`, `sp_q-1` and `sp_q-2`. It leaves the pointer 3 lower and asserts `pc_load` with `pc_new` = `tgt_in`.
- R5: A relative call (`op_kind` = 3) stacks the same three bytes as R4. `pc_new` is `ret_pc` plus `tgt_in` taken as a signed offset, wrapping modulo 2^22.
- R6: A return (`op_kind` = 4) reads `sp_q+1`, `sp_q+2` and `sp_q+3` as bits 7:0, 15:8 and 23:16 of the return address. It leaves the pointer 3 higher and asserts `pc_load` with the reassembled value.
- R7: `busy` is high for exactly one cycle per byte moved (1 for push/pop, 3 for call/return). `done` pulses for one cycle in the cycle in which `busy` has just fallen.
- R8: A byte whose address is at or above `MEM_BYTES` is not written and does not move the pointer. It ends the operation at once with `oob_err` high together with `done`, and `pc_load` stays low. Bytes already moved stay done.
- R9: Writing I/O address 0x003D sets pointer bits 7:0, and writing 0x003E sets bits 15:8, while idle. `io_rdata` returns the matching pointer byte for these two addresses and 0x00 for any other address.
- R10: An I/O write to the pointer addresses while `busy` is high is ignored.
- R11: Pointer arithmetic wraps at 16 bits: a pop at 0xFFFF reads address 0x0000, and a push at 0x0000 leaves the pointer at 0xFFFF.
- R12: `op_valid` is ignored while `busy` is high. Codes 5 to 7 on `op_kind` are never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Request an operation (taken when idle) |
| op_kind | input | 3 | 0 push, 1 pop, 2 call, 3 relative call, 4 return |
| push_byte | input | 8 | Byte to push |
| ret_pc | input | 22 | Address of the instruction after the call |
| tgt_in | input | 22 | Call target, or signed offset for a relative call |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| oob_err | output | 1 | Operation aborted on an out-of-range address (with `done`) |
| pop_byte | output | 8 | Popped byte, valid with `done` |
| pc_load | output | 1 | Load `pc_new` into the program counter |
| pc_new | output | 22 | New program counter value |
| sp_q | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Data memory address |
| mem_wdata | output | 8 | Data memory write byte |
| mem_we | output | 1 | Data memory write enable |
| mem_rdata | input | 8 | Data memory read byte (same-cycle read) |
| io_we | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | I/O read byte for the pointer addresses |

## Verification
On every cycle, the assertions check these rules: a write never lands outside memory, each write moves the pointer down by one from the address written, an error or a program-counter load only comes with `done`, `done` never repeats, and the pointer is still while idle without an I/O write. The bench scenarios cover the rest. These are the byte order of calls and returns, relative-target arithmetic with wrap, busy lengths, partial calls that run off the 16-bit wrap into the error range, and interference ignored during an operation. They also cover pop values read back from earlier pushes.

// File: rtl/stack_engine_pkg.sv
// Shared operation codes for the stack engine.
// Assumes a 3-bit operation field from the core; codes above 4 are illegal.
package stack_engine_pkg;
    typedef enum logic [2:0] {
        OP_PUSH  = 3'd0,
        OP_POP   = 3'd1,
        OP_CALL  = 3'd2,
        OP_RCALL = 3'd3,
        OP_RET   = 3'd4
    } stk_op_e;

    // True for the codes the engine accepts.
    function automatic logic op_legal(input logic [2:0] k);
        return k <= 3'd4;
    endfunction
endpackage

// File: rtl/stack_ptr.sv
// Stack pointer register with its two memory-mapped byte views.
// Assumes the sequencer never asks to step up and down in one cycle;
// software writes are honoured only when io_allow is high.
module stack_ptr #(
    parameter logic [15:0] SP_RESET   = 16'h0FFF,
    parameter logic [15:0] SP_LO_ADDR = 16'h003D,
    parameter logic [15:0] SP_HI_ADDR = 16'h003E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dec_en,
    input  logic        inc_en,
    input  logic        io_allow,
    input  logic        io_we,
    input  logic [15:0] io_addr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic [15:0] sp
);
    // Pointer update: sequencer steps take priority over software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= SP_RESET;
        end else if (dec_en) begin
            sp <= sp - 16'd1;
        end else if (inc_en) begin
            sp <= sp + 16'd1;
        end else if (io_allow && io_we) begin
            if (io_addr == SP_LO_ADDR) begin
                sp[7:0] <= io_wdata;
            end else if (io_addr == SP_HI_ADDR) begin
                sp[15:8] <= io_wdata;
            end
        end
    end

    // Read view of the two pointer bytes.
    always_comb begin
        if (io_addr == SP_LO_ADDR)      io_rdata = sp[7:0];
        else if (io_addr == SP_HI_ADDR) io_rdata = sp[15:8];
        else                            io_rdata = 8'h00;
    end
endmodule

// File: rtl/stack_seq.sv
// Byte sequencer: accepts one operation when idle and moves one byte per
// clock through the memory port until the last byte or an out-of-range
// address. Assumes memory read data is valid in the same cycle as its address.
module stack_seq
    import stack_engine_pkg::*;
#(
    parameter int MEM_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [2:0]  op_kind,
    input  logic [15:0] sp,
    output logic        accept,
    output logic [2:0]  cur_op,
    output logic [1:0]  byte_idx,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic        dec_en,
    output logic        inc_en,
    output logic        cap_en,
    output logic        busy,
    output logic        done,
    output logic        oob_err
);
    logic        run_q;
    logic        is_wr;
    logic [1:0]  last_idx;
    logic [15:0] addr_c;
    logic        oob;
    logic        xfer_ok;

    // Decode the running operation and the address of the current byte.
    always_comb begin
        is_wr    = (cur_op == OP_PUSH) || (cur_op == OP_CALL) || (cur_op == OP_RCALL);
        last_idx = ((cur_op == OP_PUSH) || (cur_op == OP_POP)) ? 2'd0 : 2'd2;
        addr_c   = is_wr ? sp : (sp + 16'd1);
        oob      = run_q && (32'(addr_c) >= MEM_BYTES);
        xfer_ok  = run_q && !oob;
    end

    assign accept   = !run_q && op_valid && op_legal(op_kind);
    assign busy     = run_q;
    assign mem_addr = run_q ? addr_c : 16'h0000;
    assign mem_we   = xfer_ok && is_wr;
    assign dec_en   = xfer_ok && is_wr;
    assign inc_en   = xfer_ok && !is_wr;
    assign cap_en   = xfer_ok && !is_wr;

    // Operation state: start, byte counting, and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            cur_op   <= OP_PUSH;
            byte_idx <= 2'd0;
            done     <= 1'b0;
            oob_err  <= 1'b0;
        end else begin
            done    <= 1'b0;
            oob_err <= 1'b0;
            if (accept) begin
                run_q    <= 1'b1;
                cur_op   <= op_kind;
                byte_idx <= 2'd0;
            end else if (run_q) begin
                if (oob || (byte_idx == last_idx)) begin
                    run_q   <= 1'b0;
                    done    <= 1'b1;
                    oob_err <= oob;
                end else begin
                    byte_idx <= byte_idx + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/stack_frame.sv
// Frame data path: latches the operands of an accepted operation, picks the
// byte to write, gathers popped bytes and forms the new program counter.
// Assumes 17 <= PC_W <= 24 so the return address spans three bytes.
module stack_frame
    import stack_engine_pkg::*;
#(
    parameter int PC_W = 22
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [7:0]      push_byte,
    input  logic [PC_W-1:0] ret_pc,
    input  logic [PC_W-1:0] tgt_in,
    input  logic [2:0]      cur_op,
    input  logic [1:0]      byte_idx,
    input  logic            cap_en,
    input  logic [7:0]      mem_rdata,
    output logic [7:0]      wr_byte,
    output logic [PC_W-1:0] pc_new,
    output logic [7:0]      pop_byte
);
    localparam int TOP_W = PC_W - 16;

    logic [7:0]      push_q;
    logic [PC_W-1:0] ret_q;
    logic [PC_W-1:0] tgt_q;
    logic [PC_W-1:0] asm_q;

    // Operand capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_q <= 8'h00;
            ret_q  <= '0;
            tgt_q  <= '0;
        end else if (accept) begin
            push_q <= push_byte;
            ret_q  <= ret_pc;
            tgt_q  <= tgt_in;
        end
    end

    // Gather popped bytes, lowest byte first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q <= '0;
        end else if (cap_en) begin
            case (byte_idx)
                2'd0:    asm_q[7:0]       <= mem_rdata;
                2'd1:    asm_q[15:8]      <= mem_rdata;
                default: asm_q[PC_W-1:16] <= mem_rdata[TOP_W-1:0];
            endcase
        end
    end

    // Byte to write: pushed byte, or return address highest byte first.
    always_comb begin
        if (cur_op == OP_PUSH) begin
            wr_byte = push_q;
        end else begin
            case (byte_idx)
                2'd0:    wr_byte = 8'(ret_q[PC_W-1:16]);
                2'd1:    wr_byte = ret_q[15:8];
                default: wr_byte = ret_q[7:0];
            endcase
        end
    end

    // New program counter per operation kind.
    always_comb begin
        case (cur_op)
            OP_CALL:  pc_new = tgt_q;
            OP_RCALL: pc_new = ret_q + tgt_q;
            OP_RET:   pc_new = asm_q;
            default:  pc_new = '0;
        endcase
    end

    assign pop_byte = asm_q[7:0];
endmodule

// File: rtl/stack_engine.sv
// Top of the call/return stack engine: pointer register, byte sequencer and
// frame data path. Assumes one operation at a time from the core and a data
// memory with synchronous write and same-cycle read.
module stack_engine
    import stack_engine_pkg::*;
#(
    parameter int          MEM_BYTES  = 4096,
    parameter int          PC_W       = 22,
    parameter logic [15:0] SP_RESET   = 16'(MEM_BYTES - 1),
    parameter logic [15:0] SP_LO_ADDR = 16'h003D,
    parameter logic [15:0] SP_HI_ADDR = 16'h003E
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_kind,
    input  logic [7:0]      push_byte,
    input  logic [PC_W-1:0] ret_pc,
    input  logic [PC_W-1:0] tgt_in,
    output logic            busy,
    output logic            done,
    output logic            oob_err,
    output logic [7:0]      pop_byte,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_new,
    output logic [15:0]     sp_q,
    output logic [15:0]     mem_addr,
    output logic [7:0]      mem_wdata,
    output logic            mem_we,
    input  logic [7:0]      mem_rdata,
    input  logic            io_we,
    input  logic [15:0]     io_addr,
    input  logic [7:0]      io_wdata,
    output logic [7:0]      io_rdata
);
    logic       accept;
    logic [2:0] cur_op;
    logic [1:0] byte_idx;
    logic       dec_en;
    logic       inc_en;
    logic       cap_en;

    stack_ptr #(
        .SP_RESET  (SP_RESET),
        .SP_LO_ADDR(SP_LO_ADDR),
        .SP_HI_ADDR(SP_HI_ADDR)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec_en  (dec_en),
        .inc_en  (inc_en),
        .io_allow(!busy),
        .io_we   (io_we),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .io_rdata(io_rdata),
        .sp      (sp_q)
    );

    stack_seq #(
        .MEM_BYTES(MEM_BYTES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_valid(op_valid),
        .op_kind (op_kind),
        .sp      (sp_q),
        .accept  (accept),
        .cur_op  (cur_op),
        .byte_idx(byte_idx),
        .mem_addr(mem_addr),
        .mem_we  (mem_we),
        .dec_en  (dec_en),
        .inc_en  (inc_en),
        .cap_en  (cap_en),
        .busy    (busy),
        .done    (done),
        .oob_err (oob_err)
    );

    stack_frame #(
        .PC_W(PC_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .push_byte(push_byte),
        .ret_pc   (ret_pc),
        .tgt_in   (tgt_in),
        .cur_op   (cur_op),
        .byte_idx (byte_idx),
        .cap_en   (cap_en),
        .mem_rdata(mem_rdata),
        .wr_byte  (mem_wdata),
        .pc_new   (pc_new),
        .pop_byte (pop_byte)
    );

    // Program counter load on a clean finish of a call or return.
    assign pc_load = done && !oob_err &&
                     ((cur_op == OP_CALL) || (cur_op == OP_RCALL) || (cur_op == OP_RET));
endmodule

// File: rtl/stack_engine_chk.sv
// Protocol checker for the stack engine, bound to every instance of the top.
module stack_engine_chk #(
    parameter int MEM_BYTES = 4096
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        oob_err,
    input logic        pc_load,
    input logic [15:0] sp_q,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        io_we
);
    p_we_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (32'(mem_addr) < MEM_BYTES));

    p_write_steps_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_q == $past(mem_addr) - 16'd1));

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oob_err |-> done);

    p_pcload_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (done && !oob_err));

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !io_we) |=> $stable(sp_q));
endmodule

bind stack_engine stack_engine_chk #(.MEM_BYTES(MEM_BYTES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .oob_err (oob_err),
    .pc_load (pc_load),
    .sp_q    (sp_q),
    .mem_addr(mem_addr),
    .mem_we  (mem_we),
    .io_we   (io_we)
);

// File: tb/stack_engine_tb.sv
`timescale 1ns/1ps
module stack_engine_tb;
    localparam int MEM_BYTES = 4096;
    localparam logic [15:0] LO = 16'h003D;
    localparam logic [15:0] HI = 16'h003E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = 3'd0;
    logic [7:0]  push_byte = 8'h00;
    logic [21:0] ret_pc = '0;
    logic [21:0] tgt_in = '0;
    logic        busy, done, oob_err, pc_load, mem_we;
    logic [7:0]  pop_byte, mem_wdata, mem_rdata, io_rdata;
    logic [21:0] pc_new;
    logic [15:0] sp_q, mem_addr;
    logic        io_we = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [7:0]  io_wdata = 8'h00;

    logic [7:0]  tmem [0:MEM_BYTES-1];
    logic [23:0] exp_q [$];
    int nchk = 0;
    int nfail = 0;
    string wr_tag = "R2";

    always #2 clk = ~clk;

    stack_engine u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .push_byte(push_byte), .ret_pc(ret_pc), .tgt_in(tgt_in),
        .busy(busy), .done(done), .oob_err(oob_err), .pop_byte(pop_byte),
        .pc_load(pc_load), .pc_new(pc_new), .sp_q(sp_q),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .io_we(io_we), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    // Memory model: synchronous write, same-cycle read.
    assign mem_rdata = (32'(mem_addr) < MEM_BYTES) ? tmem[mem_addr[11:0]] : 8'h00;
    always @(posedge clk) if (mem_we && (32'(mem_addr) < MEM_BYTES)) tmem[mem_addr[11:0]] <= mem_wdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: every memory write must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                chk({wr_tag, " unexpected write"}, {8'h00, mem_addr, mem_wdata}, 32'hFFFF_FFFF);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk({wr_tag, " write"}, {8'h00, mem_addr, mem_wdata}, {8'h00, e});
            end
        end
    end

    task automatic exp_wr(input logic [15:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); io_we = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk); io_we = 1'b0;
    endtask

    // Driver: issue one operation, wait for busy to drop, return busy length.
    task automatic run_op(input logic [2:0] k, input logic [21:0] rp, input logic [21:0] tg,
                          input logic [7:0] pb, input bit intf, output int cyc);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; ret_pc = rp; tgt_in = tg; push_byte = pb;
        @(negedge clk);
        op_valid = 1'b0; cyc = 0;
        if (intf) begin
            op_valid = 1'b1; op_kind = 3'd0; push_byte = 8'hEE;
            io_we = 1'b1; io_addr = LO; io_wdata = 8'h55;
        end
        while (busy && cyc < 10) begin
            cyc++;
            @(negedge clk);
            if (intf && cyc == 1) begin op_valid = 1'b0; io_we = 1'b0; end
        end
    endtask

    task automatic end_chk(input string tag, input int cyc, input int exp_cyc,
                           input logic err, input logic [15:0] sp_exp);
        chk({tag, " busy length"}, 32'(cyc), 32'(exp_cyc));
        chk({tag, " done"}, {31'd0, done}, 32'd1);
        chk({tag, " oob_err"}, {31'd0, oob_err}, {31'd0, err});
        chk({tag, " sp"}, {16'd0, sp_q}, {16'd0, sp_exp});
        chk({tag, " writes all seen"}, 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int c;
        for (int i = 0; i < MEM_BYTES; i++) tmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sp", {16'd0, sp_q}, 32'h0FFF);
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 done", {31'd0, done}, 0);
        chk("R1 pc_load", {31'd0, pc_load}, 0);

        // R2 pushes
        wr_tag = "R2";
        exp_wr(16'h0FFF, 8'hA5);
        run_op(3'd0, 0, 0, 8'hA5, 0, c); end_chk("R2", c, 1, 0, 16'h0FFE);
        exp_wr(16'h0FFE, 8'h3C);
        run_op(3'd0, 0, 0, 8'h3C, 0, c); end_chk("R2", c, 1, 0, 16'h0FFD);

        // R3 pops return the pushed bytes in reverse order
        run_op(3'd1, 0, 0, 0, 0, c); end_chk("R3", c, 1, 0, 16'h0FFE);
        chk("R3 pop_byte", {24'd0, pop_byte}, 32'h3C);
        run_op(3'd1, 0, 0, 0, 0, c); end_chk("R3", c, 1, 0, 16'h0FFF);
        chk("R3 pop_byte", {24'd0, pop_byte}, 32'hA5);

        // R4 absolute call, R7 three busy cycles
        wr_tag = "R4";
        exp_wr(16'h0FFF, 8'h1B); exp_wr(16'h0FFE, 8'hCD); exp_wr(16'h0FFD, 8'hEF);
        run_op(3'd2, 22'h1BCDEF, 22'h012345, 0, 0, c); end_chk("R4 R7", c, 3, 0, 16'h0FFC);
        chk("R4 pc_load", {31'd0, pc_load}, 1);
        chk("R4 pc_new", {10'd0, pc_new}, 32'h012345);

        // R6 return rebuilds the address
        run_op(3'd4, 0, 0, 0, 0, c); end_chk("R6 R7", c, 3, 0, 16'h0FFF);
        chk("R6 pc_load", {31'd0, pc_load}, 1);
        chk("R6 pc_new", {10'd0, pc_new}, 32'h1BCDEF);

        // R5 relative calls, forward with wrap and backward
        wr_tag = "R5";
        exp_wr(16'h0FFF, 8'h3F); exp_wr(16'h0FFE, 8'hFF); exp_wr(16'h0FFD, 8'hFE);
        run_op(3'd3, 22'h3FFFFE, 22'h000005, 0, 0, c); end_chk("R5", c, 3, 0, 16'h0FFC);
        chk("R5 pc_new wrap", {10'd0, pc_new}, 32'h000003);
        exp_wr(16'h0FFC, 8'h00); exp_wr(16'h0FFB, 8'h00); exp_wr(16'h0FFA, 8'h10);
        run_op(3'd3, 22'h000010, 22'h3FFFFD, 0, 0, c); end_chk("R5", c, 3, 0, 16'h0FF9);
        chk("R5 pc_new back", {10'd0, pc_new}, 32'h00000D);
        run_op(3'd4, 0, 0, 0, 0, c); end_chk("R6", c, 3, 0, 16'h0FFC);
        chk("R6 pc_new nested", {10'd0, pc_new}, 32'h000010);
        run_op(3'd4, 0, 0, 0, 0, c); end_chk("R6", c, 3, 0, 16'h0FFF);
        chk("R6 pc_new outer", {10'd0, pc_new}, 32'h3FFFFE);

        // R8 pop reaching MEM_BYTES is aborted
        wr_tag = "R8";
        run_op(3'd1, 0, 0, 0, 0, c); end_chk("R8 pop", c, 1, 1, 16'h0FFF);
        chk("R8 pc_load", {31'd0, pc_load}, 0);

        // R9 software pointer access
        io_wr(HI, 8'h00); io_wr(LO, 8'h01);
        @(negedge clk);
        chk("R9 sp", {16'd0, sp_q}, 32'h0001);
        io_addr = LO; #0.1;
        chk("R9 read low", {24'd0, io_rdata}, 32'h01);
        io_addr = HI; #0.1;
        chk("R9 read high", {24'd0, io_rdata}, 32'h00);
        io_addr = 16'h0020; #0.1;
        chk("R9 read other", {24'd0, io_rdata}, 32'h00);

        // R8 R11 call that wraps past 0x0000 into the error range
        wr_tag = "R8";
        exp_wr(16'h0001, 8'h24); exp_wr(16'h0000, 8'h68);
        run_op(3'd2, 22'h2468AC, 22'h000000, 0, 0, c); end_chk("R8 R11 call", c, 3, 1, 16'hFFFF);
        chk("R8 pc_load", {31'd0, pc_load}, 0);

        // R11 pop at 0xFFFF reads 0x0000, push at 0x0000 wraps
        run_op(3'd1, 0, 0, 0, 0, c); end_chk("R11 pop", c, 1, 0, 16'h0000);
        chk("R11 pop_byte", {24'd0, pop_byte}, 32'h68);
        wr_tag = "R11";
        exp_wr(16'h0000, 8'h77);
        run_op(3'd0, 0, 0, 8'h77, 0, c); end_chk("R11 push", c, 1, 0, 16'hFFFF);

        // R10 R12 interference while busy is ignored
        io_wr(HI, 8'h08); io_wr(LO, 8'h00);
        wr_tag = "R12";
        exp_wr(16'h0800, 8'h00); exp_wr(16'h07FF, 8'h01); exp_wr(16'h07FE, 8'h00);
        run_op(3'd2, 22'h000100, 22'h000200, 0, 1, c); end_chk("R10 R12", c, 3, 0, 16'h07FD);
        repeat (2) @(negedge clk);
        chk("R12 stays idle", {31'd0, busy}, 0);
        chk("R10 sp kept", {16'd0, sp_q}, 32'h07FD);

        // R12 undefined code is never accepted
        @(negedge clk); op_valid = 1'b1; op_kind = 3'd5;
        @(negedge clk); op_valid = 1'b0;
        chk("R12 illegal code busy", {31'd0, busy}, 0);
        @(negedge clk);
        chk("R12 illegal code sp", {16'd0, sp_q}, 32'h07FD);

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule